// File: doc/BRIEF.md
# Hot-Swap Bus Join Sequencer

This controller decides when a plug-in board's two-wire bus segment may be tied to the backplane segment after the board is inserted or enabled. It sees the clock and data line levels on both sides, an enable request and a supply-good flag. From these it drives four controls: a join command for the analog switch, a precharge enable, a high-impedance control for all bus pins, and a ready status that reports the joined state.

When the board is enabled and its supply is good, the pins leave high impedance and precharge starts. A settle interval (SETTLE_US microseconds) then runs. After it, the sequencer waits on the backplane side for one of two events: a stop condition, or a quiet bus where both lines stay high for IDLE_US microseconds. The board-side lines must also both be high at that point. Only then is the join made and precharge released. The interval timers count microsecond ticks produced by a prescaler that is derived from CLK_HZ. A separate fault block can pulse a force input to send the sequencer back to waiting with precharge on.

All level inputs pass through SYNC_STAGES flip-flops before any decision is made. The force input is treated as on-chip and synchronous.

Top module: `bus_join_seq`

## Requirements
- R1: While reset is held or the synchronized enable/supply-good gate is low, the outputs are {hiz_o,precharge_o,connect_o,ready_o} = 1000. This holds during reset even if enable and supply-good are high.
- R2: When en_i and pwr_ok_i are both high, the outputs stay 1000 after two clock edges and become 0100 (precharge on, not joined) at the third edge.
- R3: No join happens during the settle interval of SETTLE_US*(CLK_HZ/1e6) cycles that begins when precharge starts, even if the backplane shows a stop condition.
- R4: While waiting with both board lines high, a rising backplane data line while backplane clock is high (a stop) joins the buses at the third clock edge after the data line rises.
- R5: A rising backplane data line while backplane clock is low is not a stop and causes no join.
- R6: The join is made once both backplane lines have been high continuously for IDLE_US microseconds during waiting, counted from entry to waiting. A low on either line restarts the count.
- R7: No join is made while either board line is low. When an idle-qualified wait ends with the board low, the join follows at the third edge after the board lines become high.
- R8: In the joined state the outputs are 0011: connect and ready high, precharge off, pins not high-impedance. Ready is high in no other state.
- R9: A low on en_i or on pwr_ok_i returns the outputs to 1000 at the third clock edge, from any state.
- R10: A one-cycle high on force_wait_i in any state other than low power moves the sequencer to waiting (outputs 0100) at the next edge and restarts the idle count. In low power, the pulse has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Board enable request (asynchronous) |
| pwr_ok_i | input | 1 | Supply-good flag (asynchronous) |
| bp_scl_i | input | 1 | Backplane clock line level |
| bp_sda_i | input | 1 | Backplane data line level |
| bd_scl_i | input | 1 | Board clock line level |
| bd_sda_i | input | 1 | Board data line level |
| force_wait_i | input | 1 | Synchronous pulse from fault logic: return to waiting |
| connect_o | output | 1 | Join the two bus segments |
| precharge_o | output | 1 | Enable line precharge |
| hiz_o | output | 1 | Hold all bus pins high-impedance |
| ready_o | output | 1 | Buses joined status |

## Verification
Every asynchronous input crosses two synchronizer flops before it reaches the state register. A change in enable, supply-good or a line level therefore shows at the outputs on the third clock edge, while force_wait_i acts on the first. The interval timers add exact delays of SETTLE_US*4 and IDLE_US*4 cycles at the bench's 4 MHz tick setting. The bench drives each stimulus on a falling clock edge and then counts falling edges. It checks the old output value one edge before the change is due and the new value exactly at the due edge. This pins every latency to the cycle.

// File: rtl/bjs_pkg.sv
package bjs_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_LIVE   = 2'd3
    } seq_state_e;

    // Number of clock cycles per microsecond tick, never below one.
    function automatic int unsigned tick_div(input int unsigned clk_hz);
        int unsigned d;
        d = clk_hz / 1_000_000;
        return (d == 0) ? 1 : d;
    endfunction

endpackage

// File: rtl/bjs_sync.sv
module bjs_sync #(
    parameter int unsigned  W       = 1,
    parameter int unsigned  STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] stg_d;
        if (g == 0) begin : g_first
            assign stg_d = d_i;
        end else begin : g_next
            assign stg_d = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= RST_VAL;
            else        stg_q[g] <= stg_d;
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/bjs_usec_timer.sv
module bjs_usec_timer #(
    parameter int unsigned DIV   = 100,
    parameter int unsigned LIMIT = 130
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic reached_o
);

    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int unsigned UW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);
    localparam logic [UW-1:0] US_LAST  = UW'(LIMIT - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [UW-1:0] us;
        logic          sat;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic hit;

    always_comb begin
        tmr_d = tmr_q;
        hit   = 1'b0;
        if (clr_i) begin
            tmr_d = '0;
        end else if (!tmr_q.sat) begin
            if (tmr_q.pre == PRE_LAST) begin
                tmr_d.pre = '0;
                if (tmr_q.us == US_LAST) begin
                    tmr_d.sat = 1'b1;
                    hit       = 1'b1;
                end else begin
                    tmr_d.us = tmr_q.us + 1'b1;
                end
            end else begin
                tmr_d.pre = tmr_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign reached_o = hit | tmr_q.sat;

endmodule

// File: rtl/bus_join_seq.sv
module bus_join_seq #(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned SETTLE_US   = 130,
    parameter int unsigned IDLE_US     = 140,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic pwr_ok_i,
    input  logic bp_scl_i,
    input  logic bp_sda_i,
    input  logic bd_scl_i,
    input  logic bd_sda_i,
    input  logic force_wait_i,
    output logic connect_o,
    output logic precharge_o,
    output logic hiz_o,
    output logic ready_o
);

    import bjs_pkg::*;

    localparam int unsigned TICK_DIV = tick_div(CLK_HZ);
    localparam int unsigned NSYNC    = 6;

    // Synchronized view of all asynchronous inputs
    logic [NSYNC-1:0] raw, syn;
    logic gate_s, bp_scl_s, bp_sda_s, bd_hi_s, bp_hi_s;
    logic bd_scl_s, bd_sda_s, en_s, pok_s;

    assign raw = {en_i, pwr_ok_i, bp_scl_i, bp_sda_i, bd_scl_i, bd_sda_i};

    bjs_sync #(
        .W       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (6'b00_1111)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    assign {en_s, pok_s, bp_scl_s, bp_sda_s, bd_scl_s, bd_sda_s} = syn;
    assign gate_s  = en_s & pok_s;
    assign bp_hi_s = bp_scl_s & bp_sda_s;
    assign bd_hi_s = bd_scl_s & bd_sda_s;

    typedef struct packed {
        seq_state_e st;
        logic       sda_prev;
    } seq_t;

    seq_t seq_d, seq_q;

    // Interval timers
    logic settle_clr, settle_done;
    logic idle_clr, idle_done;

    assign settle_clr = (seq_q.st != ST_SETTLE);
    assign idle_clr   = (seq_q.st != ST_WAIT) | ~bp_hi_s | force_wait_i;

    bjs_usec_timer #(
        .DIV   (TICK_DIV),
        .LIMIT (SETTLE_US)
    ) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (settle_clr),
        .reached_o (settle_done)
    );

    bjs_usec_timer #(
        .DIV   (TICK_DIV),
        .LIMIT (IDLE_US)
    ) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (idle_clr),
        .reached_o (idle_done)
    );

    // Stop: data rises while clock stays high (synchronized values)
    logic stop_seen;
    assign stop_seen = bp_scl_s & bp_sda_s & ~seq_q.sda_prev;

    always_comb begin
        seq_d          = seq_q;
        seq_d.sda_prev = bp_sda_s;
        if (!gate_s) begin
            seq_d.st = ST_OFF;
        end else begin
            unique case (seq_q.st)
                ST_OFF:    seq_d.st = ST_SETTLE;
                ST_SETTLE: if (force_wait_i || settle_done) seq_d.st = ST_WAIT;
                ST_WAIT:   if (!force_wait_i && (stop_seen || idle_done) && bd_hi_s)
                               seq_d.st = ST_LIVE;
                ST_LIVE:   if (force_wait_i) seq_d.st = ST_WAIT;
                default:   seq_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_OFF, sda_prev: 1'b1};
        else        seq_q <= seq_d;
    end

    always_comb begin
        hiz_o       = (seq_q.st == ST_OFF);
        precharge_o = (seq_q.st == ST_SETTLE) || (seq_q.st == ST_WAIT);
        connect_o   = (seq_q.st == ST_LIVE);
        ready_o     = (seq_q.st == ST_LIVE);
    end

endmodule

// File: rtl/bus_join_seq_chk.sv
module bus_join_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic pwr_ok_i,
    input logic force_wait_i,
    input logic connect_o,
    input logic precharge_o,
    input logic hiz_o,
    input logic ready_o,
    input logic gate_s,
    input logic bd_hi_s
);

    logic [1:0] off_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   off_cnt_q <= 2'd0;
        else if (en_i && pwr_ok_i)    off_cnt_q <= 2'd0;
        else if (off_cnt_q != 2'd3)   off_cnt_q <= off_cnt_q + 2'd1;
    end

    // R1: high-impedance pins mean everything else is off
    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_o |-> (!connect_o && !precharge_o && !ready_o));

    // R9: three cycles of a low gate always land in low power
    a_r9_drop_reaches_off: assert property (@(posedge clk) disable iff (!rst_n)
        (off_cnt_q == 2'd3) |-> hiz_o);

    // R2: leaving low power starts with precharge, not a join
    a_r2_wake_precharged: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hiz_o) |-> (precharge_o && !connect_o));

    // R6: a join always comes out of the precharged wait
    a_r6_join_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect_o) |-> $past(precharge_o));

    // R7: the board side was high when the join was decided
    a_r7_board_high_at_join: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connect_o) |-> $past(bd_hi_s));

    // R8: ready only with the join made and precharge released
    a_r8_ready_only_live: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (connect_o && !precharge_o && !hiz_o));

    // R10: force pulse sends an awake sequencer back to waiting
    a_r10_force_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (force_wait_i && !hiz_o && gate_s) |=> (precharge_o && !connect_o));

endmodule

bind bus_join_seq bus_join_seq_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .pwr_ok_i     (pwr_ok_i),
    .force_wait_i (force_wait_i),
    .connect_o    (connect_o),
    .precharge_o  (precharge_o),
    .hiz_o        (hiz_o),
    .ready_o      (ready_o),
    .gate_s       (gate_s),
    .bd_hi_s      (bd_hi_s)
);

// File: tb/bus_join_seq_tb_top.sv
`timescale 1ns/1ps
module bus_join_seq_tb_top;

    // 4 MHz tick base: 4 cycles per microsecond
    localparam int unsigned SETTLE_CYC = 130 * 4;
    localparam int unsigned IDLE_CYC   = 140 * 4;
    localparam logic [3:0] O_OFF  = 4'b1000;
    localparam logic [3:0] O_HOLD = 4'b0100;
    localparam logic [3:0] O_LIVE = 4'b0011;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, en_i, pwr_ok_i, bp_scl_i, bp_sda_i, bd_scl_i, bd_sda_i, force_wait_i;
    logic connect_o, precharge_o, hiz_o, ready_o;

    bus_join_seq #(
        .CLK_HZ    (4_000_000),
        .SETTLE_US (130),
        .IDLE_US   (140)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .pwr_ok_i     (pwr_ok_i),
        .bp_scl_i     (bp_scl_i),
        .bp_sda_i     (bp_sda_i),
        .bd_scl_i     (bd_scl_i),
        .bd_sda_i     (bd_sda_i),
        .force_wait_i (force_wait_i),
        .connect_o    (connect_o),
        .precharge_o  (precharge_o),
        .hiz_o        (hiz_o),
        .ready_o      (ready_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {hiz_o, precharge_o, connect_o, ready_o};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {hiz,pre,con,rdy}=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic go_off();
        en_i = 1'b0;
        wait_n(4);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; en_i = 1'b1; pwr_ok_i = 1'b1; force_wait_i = 1'b0;
        bp_scl_i = 1'b1; bp_sda_i = 1'b1; bd_scl_i = 1'b1; bd_sda_i = 1'b1;
        wait_n(5);
        check("R1 in reset", O_OFF);
        en_i = 1'b0;
        rst_n = 1'b1;
        wait_n(5);
        check("R1 gate low", O_OFF);
    endtask

    task automatic t_enable_settle_stop();
        bp_sda_i = 1'b0;
        en_i = 1'b1;
        wait_n(2);  check("R2 two edges", O_OFF);
        wait_n(1);  check("R2 third edge", O_HOLD);
        wait_n(47);
        bp_sda_i = 1'b1;               // stop inside settle window
        wait_n(5);  check("R3 stop during settle", O_HOLD);
        bp_sda_i = 1'b0;
        wait_n(475);                   // past 3 + SETTLE_CYC
        bp_sda_i = 1'b1;               // stop in wait
        wait_n(2);  check("R4 stop two edges", O_HOLD);
        wait_n(1);  check("R4 R8 stop joins", O_LIVE);
    endtask

    task automatic t_disable();
        en_i = 1'b0;
        wait_n(2);  check("R9 en low two edges", O_LIVE);
        wait_n(1);  check("R9 en low third edge", O_OFF);
    endtask

    task automatic t_rise_scl_low();
        bp_scl_i = 1'b0; bp_sda_i = 1'b0;
        wait_n(4);
        en_i = 1'b1;
        wait_n(3 + SETTLE_CYC + 7);
        bp_sda_i = 1'b1;
        wait_n(6);  check("R5 data rise clock low", O_HOLD);
        bp_scl_i = 1'b1;
        wait_n(6);  check("R5 clock rise after data", O_HOLD);
        bp_sda_i = 1'b0;
        wait_n(4);
        bp_sda_i = 1'b1;
        wait_n(2);  check("R4 second stop two edges", O_HOLD);
        wait_n(1);  check("R4 second stop joins", O_LIVE);
        go_off();
    endtask

    task automatic t_idle();
        en_i = 1'b1;
        wait_n(3 + SETTLE_CYC + IDLE_CYC - 1);
        check("R6 idle one short", O_HOLD);
        wait_n(1);  check("R6 idle joins", O_LIVE);
        go_off();
    endtask

    task automatic t_idle_restart();
        en_i = 1'b1;
        wait_n(700);
        bp_scl_i = 1'b0;
        wait_n(1);
        bp_scl_i = 1'b1;
        wait_n(399); check("R6 restart past first deadline", O_HOLD);
        wait_n(162); check("R6 restart one short", O_HOLD);
        wait_n(1);   check("R6 restart joins", O_LIVE);
        go_off();
    endtask

    task automatic t_board_low();
        bd_scl_i = 1'b0;
        en_i = 1'b1;
        wait_n(1090); check("R7 board low blocks", O_HOLD);
        bd_scl_i = 1'b1;
        wait_n(2);   check("R7 board high two edges", O_HOLD);
        wait_n(1);   check("R7 board high joins", O_LIVE);
    endtask

    task automatic t_force();
        force_wait_i = 1'b1;
        wait_n(1);
        force_wait_i = 1'b0;
        check("R10 force to wait", O_HOLD);
        wait_n(IDLE_CYC - 1); check("R10 idle restarted", O_HOLD);
        wait_n(1);   check("R10 rejoin after idle", O_LIVE);
    endtask

    task automatic t_pwr_drop();
        pwr_ok_i = 1'b0;
        wait_n(2);  check("R9 supply drop two edges", O_LIVE);
        wait_n(1);  check("R9 supply drop third edge", O_OFF);
        force_wait_i = 1'b1;
        wait_n(1);
        force_wait_i = 1'b0;
        wait_n(1);  check("R10 force ignored in low power", O_OFF);
        pwr_ok_i = 1'b1;
        en_i = 1'b0;
        wait_n(4);
    endtask

    initial begin
        t_reset();
        t_enable_settle_stop();
        t_disable();
        t_rise_scl_low();
        t_idle();
        t_idle_restart();
        t_board_low();
        t_force();
        t_pwr_drop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run incomplete, expected finish before 200000 cycles");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule